// File: doc/BRIEF.md
# Chained FIFO Depth Extension by Token Ring

This block joins several equal FIFO slices into one deeper FIFO. It does not widen the pointers. Two tokens circulate around a ring of slices instead: a write token and a read token. The slice that holds the write token is the only one that stores incoming words. The slice that holds the read token is the only one that returns words.

When a slice accepts a write into its highest address, it raises its write hand-off output for that cycle. The next slice in the ring takes the write token on the same clock edge that completes the write. Reads move the read token the same way. The last slice hands off to the first, which closes the ring.

A one-hot start-owner vector is sampled while reset is held. It picks the slice that holds both tokens when reset is released. The chain-level flags are the OR of per-slice flags. Each per-slice empty, full and almost flag counts only while that slice holds the relevant token. A half-occupancy flag is not produced.

Top module: `fifo_chain`

## Requirements
- R1: While `rst` is high, slice i takes both tokens exactly when `start_owner[i]` is 1. After reset, `wr_token` and `rd_token` both equal `start_owner`, `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: Words written while `full` is 0 come back from reads in the order they were written, across every slice boundary.
- R3: The write token moves from slice i to slice i+1 on the clock edge that stores a word at address SLICE_DEPTH-1 of slice i. Every SLICE_DEPTH accepted writes move `wr_token` one position toward the higher bit.
- R4: The read token moves from slice i to slice i+1 on the clock edge that reads address SLICE_DEPTH-1 of slice i.
- R5: Both tokens move from the highest slice back to slice 0, so the ring wraps around.
- R6: `full` is 1 exactly when NUM_SLICES*SLICE_DEPTH words are stored. A write while `full` is 1 is ignored and stores nothing.
- R7: `empty` is 1 exactly when no word is stored. A read while `empty` is 1 is ignored, and `rd_valid` stays 0 in the next cycle.
- R8: `rd_valid` is 1 in the cycle after each accepted read, and `rd_data` then carries the word read. When `rd_valid` is 0, `rd_data` is zero.
- R9: `almost_empty` is 1 when the slice holding the read token has at most AE_LEVEL words.
- R10: `almost_full` is 1 when the slice holding the write token has at least SLICE_DEPTH-AF_LEVEL words.
- R11: Exactly one slice holds the write token and exactly one slice holds the read token at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole chain |
| rst | input | 1 | Synchronous active-high reset |
| start_owner | input | NUM_SLICES | One-hot choice of the slice that holds both tokens after reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word read, zero when not valid |
| rd_valid | output | 1 | rd_data holds a word read in the previous cycle |
| empty | output | 1 | No word stored |
| full | output | 1 | Every location in the chain is occupied |
| almost_empty | output | 1 | Read-token slice is at or below its low level |
| almost_full | output | 1 | Write-token slice is at or above its high level |
| wr_token | output | NUM_SLICES | One-hot position of the write token |
| rd_token | output | NUM_SLICES | One-hot position of the read token |

## Verification
The bench builds three slices of four words of eight bits, with both almost levels set to one. With these values the whole chain holds twelve words. The tokens therefore wrap around the ring many times in a few hundred cycles, and a full fill followed by a full drain goes through every hand-off, including the return from the last slice to the first.

The bench runs the complete sequence once for each possible start owner. Each run covers all four combinations of read and write request, plus a long pseudo-random mix. This exercises writes at full, reads at empty, and simultaneous read and write in the same slice and in different slices.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  function automatic int ring_prev(input int idx, input int count);
    return (idx + count - 1) % count;
  endfunction
endpackage

// File: rtl/chain_mem.sv
module chain_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/chain_token.sv
module chain_token #(
  parameter int DEPTH = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_own,
  input  logic              pass_in,
  input  logic              req,
  input  logic              blocked,
  output logic              hold,
  output logic              fire,
  output logic [ADDR_W-1:0] ptr,
  output logic              pass_out
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  assign fire     = req && hold && !blocked;
  assign pass_out = fire && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= start_own;
      ptr  <= '0;
    end else begin
      hold <= (hold && !pass_out) || pass_in;
      if (fire) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  assert_take_on_pass_R3: assert property (@(posedge clk) disable iff (rst)
    pass_in |=> hold);
  assert_keep_token_R11: assert property (@(posedge clk) disable iff (rst)
    (hold && !pass_out && !pass_in) |=> hold);
  assert_no_fire_without_token_R2: assert property (@(posedge clk) disable iff (rst)
    !hold |=> $stable(ptr));
endmodule

// File: rtl/chain_slice.sv
module chain_slice #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter int AE_LEVEL = 1,
  parameter int AF_LEVEL = 1,
  localparam int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_own,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pass_in,
  input  logic              rd_en,
  input  logic              rd_pass_in,
  output logic              wr_pass_out,
  output logic              rd_pass_out,
  output logic              wr_hold,
  output logic              rd_hold,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_v,
  output logic              full_f,
  output logic              empty_f,
  output logic              ae_f,
  output logic              af_f
);
  localparam logic [CNT_W-1:0] CAP   = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AE_TH = CNT_W'(AE_LEVEL);
  localparam logic [CNT_W-1:0] AF_TH = CNT_W'(DEPTH - AF_LEVEL);

  logic [CNT_W-1:0]  count;
  logic              at_cap, at_zero;
  logic              wfire, rfire;
  logic [ADDR_W-1:0] wptr, rptr;
  logic [DATA_W-1:0] mem_q;

  assign at_cap  = (count == CAP);
  assign at_zero = (count == '0);

  chain_token #(.DEPTH(DEPTH)) wtok_i (
    .clk(clk), .rst(rst), .start_own(start_own), .pass_in(wr_pass_in),
    .req(wr_en), .blocked(at_cap), .hold(wr_hold), .fire(wfire),
    .ptr(wptr), .pass_out(wr_pass_out)
  );

  chain_token #(.DEPTH(DEPTH)) rtok_i (
    .clk(clk), .rst(rst), .start_own(start_own), .pass_in(rd_pass_in),
    .req(rd_en), .blocked(at_zero), .hold(rd_hold), .fire(rfire),
    .ptr(rptr), .pass_out(rd_pass_out)
  );

  chain_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .we(wfire), .waddr(wptr), .wdata(wr_data),
    .re(rfire), .raddr(rptr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      rd_v  <= 1'b0;
    end else begin
      rd_v <= rfire;
      case ({wfire, rfire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_q    = rd_v ? mem_q : '0;
  assign full_f  = wr_hold && at_cap;
  assign empty_f = rd_hold && at_zero;
  assign ae_f    = rd_hold && (count <= AE_TH);
  assign af_f    = wr_hold && (count >= AF_TH);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    at_cap |=> (count <= CAP));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (at_zero && !wfire) |=> at_zero);
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int NUM_SLICES  = 3,
  parameter int SLICE_DEPTH = 4,
  parameter int DATA_W      = 8,
  parameter int AE_LEVEL    = 1,
  parameter int AF_LEVEL    = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SLICES-1:0] start_owner,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  empty,
  output logic                  full,
  output logic                  almost_empty,
  output logic                  almost_full,
  output logic [NUM_SLICES-1:0] wr_token,
  output logic [NUM_SLICES-1:0] rd_token
);
  logic [NUM_SLICES-1:0] wxo, rxo, rv, ff, ef, aef, aff;
  logic [DATA_W-1:0]     q [NUM_SLICES];

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int PREV = ring_prev(i, NUM_SLICES);
    chain_slice #(
      .DATA_W(DATA_W), .DEPTH(SLICE_DEPTH),
      .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)
    ) slice_i (
      .clk(clk), .rst(rst), .start_own(start_owner[i]),
      .wr_en(wr_en), .wr_data(wr_data), .wr_pass_in(wxo[PREV]),
      .rd_en(rd_en), .rd_pass_in(rxo[PREV]),
      .wr_pass_out(wxo[i]), .rd_pass_out(rxo[i]),
      .wr_hold(wr_token[i]), .rd_hold(rd_token[i]),
      .rd_q(q[i]), .rd_v(rv[i]),
      .full_f(ff[i]), .empty_f(ef[i]), .ae_f(aef[i]), .af_f(aff[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SLICES; i++) rd_data = rd_data | q[i];
  end

  assign rd_valid     = |rv;
  assign empty        = |ef;
  assign full         = |ff;
  assign almost_empty = |aef;
  assign almost_full  = |aff;

  assert_one_write_token_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_token) == 1);
  assert_one_read_token_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_token) == 1);
  assert_single_reader_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rv));
  assert_not_both_flags_R6: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  assert_token_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (|wxo) |=> !$stable(wr_token) || (NUM_SLICES == 1));
endmodule

// File: tb/fifo_chain_tb_top.sv
module fifo_chain_tb_top;
  localparam int N  = 3;
  localparam int D  = 4;
  localparam int W  = 8;
  localparam int AE = 1;
  localparam int AF = 1;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] start_owner;
  logic         wr_en, rd_en;
  logic [W-1:0] wr_data, rd_data;
  logic         rd_valid, empty, full, almost_empty, almost_full;
  logic [N-1:0] wr_token, rd_token;

  int checks = 0;
  int errors = 0;
  int mq[$];
  int cnt[N];
  int ws, rs, wpos, rpos, total;
  int exp_data;
  bit exp_valid;
  logic [W-1:0]  next_word;
  logic [15:0]   lfsr;

  always #2.5 clk = ~clk;

  fifo_chain #(.NUM_SLICES(N), .SLICE_DEPTH(D), .DATA_W(W),
               .AE_LEVEL(AE), .AF_LEVEL(AF)) dut_i (
    .clk(clk), .rst(rst), .start_owner(start_owner),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .wr_token(wr_token), .rd_token(rd_token)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int owner);
    start_owner = N'(1 << owner);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mq.delete();
    for (int i = 0; i < N; i++) cnt[i] = 0;
    ws = owner; rs = owner; wpos = 0; rpos = 0; total = 0;
    #1;
    chk(wr_token == N'(1 << owner), "R1 wr_token", int'(wr_token), 1 << owner);
    chk(rd_token == N'(1 << owner), "R1 rd_token", int'(rd_token), 1 << owner);
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic step(input bit w, input bit r);
    bit wacc, racc;
    wr_en = w; rd_en = r; wr_data = next_word;
    @(posedge clk);
    wacc = w && (total < N * D);
    racc = r && (total > 0);
    exp_valid = racc;
    exp_data  = 0;
    if (racc) begin
      exp_data = mq.pop_front();
      cnt[rs]--; total--;
      rpos++;
      if (rpos == D) begin rpos = 0; rs = (rs + 1) % N; end
    end
    if (wacc) begin
      mq.push_back(int'(next_word));
      cnt[ws]++; total++;
      wpos++;
      if (wpos == D) begin wpos = 0; ws = (ws + 1) % N; end
      next_word = next_word + 8'd1;
    end
    #1;
    chk(rd_valid == exp_valid, "R7 rd_valid", int'(rd_valid), int'(exp_valid));
    chk(int'(rd_data) == exp_data, "R2/R8 rd_data", int'(rd_data), exp_data);
    chk(full == (total == N * D), "R6 full", int'(full), int'(total == N * D));
    chk(empty == (total == 0), "R7 empty", int'(empty), int'(total == 0));
    chk(wr_token == N'(1 << ws), "R3/R5 wr_token", int'(wr_token), 1 << ws);
    chk(rd_token == N'(1 << rs), "R4/R5 rd_token", int'(rd_token), 1 << rs);
    chk(almost_empty == (cnt[rs] <= AE), "R9 almost_empty",
        int'(almost_empty), int'(cnt[rs] <= AE));
    chk(almost_full == (cnt[ws] >= D - AF), "R10 almost_full",
        int'(almost_full), int'(cnt[ws] >= D - AF));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    next_word = 8'd1;
    lfsr = 16'hACE1;
    for (int owner = 0; owner < N; owner++) begin
      do_reset(owner);
      step(1'b0, 1'b1);                                  // R7 read at empty
      for (int k = 0; k < N * D + 2; k++) step(1'b1, 1'b0); // R6 fill past full
      step(1'b1, 1'b1);                                  // full: read only
      for (int k = 0; k < N * D + 2; k++) step(1'b0, 1'b1); // drain past empty, R5 wrap
      for (int k = 0; k < 4; k++) step(k[0], k[1]);
      for (int k = 0; k < 200; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[3], lfsr[1] | (lfsr[5] & owner[0]));
      end
      for (int k = 0; k < N * D + 1; k++) step(1'b0, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule